// File: doc/BRIEF.md
# Compare-Triggered Pattern Output Controller

This block drives an 8-bit parallel output port from a staged pattern register. Software stages the next pattern at any time between updates. The port register takes it over only when a periodic timer event fires, so the pins never show a half-written value.

An internal up-counter runs from zero to a programmed period and then clears. Each wrap produces a one-cycle trigger pulse and sets an interrupt flag. The port is split into a low and a high nibble. Each nibble chooses its own trigger source, and a per-bit enable mask limits which bits the trigger may change. A typical use is stepping a stepper-motor phase sequence: each interrupt loads the next pattern, and the pins change together on the following trigger.

Top module: `pattern_out_ctrl`

## Requirements
- R1: After reset, port_o, port_rd_o, trig_o, irq_flag_o and irq_o are all 0. The counter is 0 and stopped.
- R2: While the run bit is 1, the counter steps by one each cycle. When it equals the period it clears to 0 and trig_o pulses for one cycle, so triggers come every period+1 cycles. With run at 0 no trigger occurs.
- R3: Each trigger sets irq_flag_o. irq_o is 1 only while both the flag and the interrupt-enable bit are 1.
- R4: Writing a value with bit 0 equal to 0 to the flag register clears the flag. Writing 1 has no effect. If the clear and a trigger fall in the same cycle, the flag stays set.
- R5: On a trigger, every bit whose mask bit is 1 (in a group whose trigger is selected) copies the staged bit into the output register. Masked-off bits keep their value. The output register never changes without a trigger.
- R6: The trigger-select register has bits [1:0] for the low nibble (port bits 3:0) and bits [3:2] for the high nibble (port bits 7:4). Code 00 selects the timer. Codes 01, 10 and 11 name absent channels and never update the group.
- R7: A staged-pattern write in the same cycle as a trigger does not affect that trigger, which transfers the previous staged value. The new value is used at the next trigger.
- R8: port_o bit i equals output register bit i when direction bit i is 1, and 0 otherwise. port_rd_o always shows the output register.
- R9: With direction and mask set to 0xF8, staging 80, C0, 40, 60, 20, 30, 10, 18, 08, 88 (hex) at successive triggers gives an output with one or two of bits 7:3 high after every trigger.
- R10: Register addresses are: 0 staged pattern, 1 mask, 2 direction, 3 trigger select, 4 period (16 bits), 5 control (bit 0 interrupt enable, bit 1 run), 6 flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| port_o | output | 8 | Driven port pins (output-direction bits only) |
| port_rd_o | output | 8 | Port read-back value (output register) |
| trig_o | output | 1 | One-cycle timer match pulse |
| irq_flag_o | output | 1 | Match interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The five-phase sequence is used as the baseline. It shows that each staged value reaches the pins exactly at a trigger, and that the masked low bits stay quiet. A partial mask (0x3C) with a staged value unlike the current output separates the bits that follow the pattern from those that hold. Mixed group-select codes show that one nibble can move while the other stays frozen, and all-absent codes show that nothing moves. Writes placed right on a trigger cycle tell "old value transferred" apart from "new value transferred", and tell "set wins" apart from "clear wins" for the flag.

// File: rtl/pat_pkg.sv
package pat_pkg;
  typedef enum logic [2:0] {
    REG_NEXT   = 3'd0,
    REG_MASK   = 3'd1,
    REG_DIR    = 3'd2,
    REG_TSEL   = 3'd3,
    REG_PERIOD = 3'd4,
    REG_CTRL   = 3'd5,
    REG_FLAG   = 3'd6
  } reg_addr_e;

  localparam int unsigned CTRL_IE_BIT  = 0;
  localparam int unsigned CTRL_RUN_BIT = 1;
endpackage

// File: rtl/pat_timer.sv
module pat_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;

  assign match_o = run_i && (cnt_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (run_i) begin
      if (match_o)    cnt_q <= '0;
      else            cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_clear_on_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> (cnt_q == '0));
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !match_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  assert_hold_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/pat_regfile.sv
module pat_regfile
  import pat_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned BUS_W      = 16,
  parameter int unsigned TSEL_W     = 4,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic              match_i,
  output logic [DATA_W-1:0] next_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] dir_o,
  output logic [TSEL_W-1:0] tsel_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              run_o,
  output logic              irq_en_o,
  output logic              flag_o
);
  logic wr_next, wr_mask, wr_dir, wr_tsel, wr_period, wr_ctrl, flag_clr;

  assign wr_next   = wr_en_i && (wr_addr_i == REG_NEXT);
  assign wr_mask   = wr_en_i && (wr_addr_i == REG_MASK);
  assign wr_dir    = wr_en_i && (wr_addr_i == REG_DIR);
  assign wr_tsel   = wr_en_i && (wr_addr_i == REG_TSEL);
  assign wr_period = wr_en_i && (wr_addr_i == REG_PERIOD);
  assign wr_ctrl   = wr_en_i && (wr_addr_i == REG_CTRL);
  assign flag_clr  = wr_en_i && (wr_addr_i == REG_FLAG) && !wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_o   <= '0;
      mask_o   <= '0;
      dir_o    <= '0;
      tsel_o   <= '0;
      period_o <= PERIOD_RST;
      run_o    <= 1'b0;
      irq_en_o <= 1'b0;
    end else begin
      if (wr_next)   next_o   <= wr_data_i[DATA_W-1:0];
      if (wr_mask)   mask_o   <= wr_data_i[DATA_W-1:0];
      if (wr_dir)    dir_o    <= wr_data_i[DATA_W-1:0];
      if (wr_tsel)   tsel_o   <= wr_data_i[TSEL_W-1:0];
      if (wr_period) period_o <= wr_data_i[CNT_W-1:0];
      if (wr_ctrl) begin
        irq_en_o <= wr_data_i[CTRL_IE_BIT];
        run_o    <= wr_data_i[CTRL_RUN_BIT];
      end
    end
  end

  // set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_o <= 1'b0;
    else if (match_i)  flag_o <= 1'b1;
    else if (flag_clr) flag_o <= 1'b0;
  end

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> flag_o);
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr && !match_i) |=> !flag_o);
  assert_flag_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr) |=> flag_o);
endmodule

// File: rtl/pat_out_stage.sv
module pat_out_stage #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned NGRP  = DATA_W / GRP_W,
  localparam int unsigned NCHAN = 1 << SEL_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NCHAN-1:0]       chan_trig_i,
  input  logic [NGRP*SEL_W-1:0]  tsel_i,
  input  logic [DATA_W-1:0]      next_i,
  input  logic [DATA_W-1:0]      mask_i,
  output logic [DATA_W-1:0]      out_o
);
  logic [NGRP-1:0]   grp_trig;
  logic [DATA_W-1:0] upd;
  logic [DATA_W-1:0] out_d;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_trig[g] = chan_trig_i[tsel_i[g*SEL_W +: SEL_W]];
    assign upd[g*GRP_W +: GRP_W] = mask_i[g*GRP_W +: GRP_W] & {GRP_W{grp_trig[g]}};

    assert_idle_group_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !grp_trig[g] |=> $stable(out_o[g*GRP_W +: GRP_W]));
  end

  assign out_d = (out_o & ~upd) | (next_i & upd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_o <= '0;
    else         out_o <= out_d;
  end

  assert_masked_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((out_o & ~$past(mask_i)) == ($past(out_o) & ~$past(mask_i))));
  assert_no_trig_no_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_trig_i == '0) |=> $stable(out_o));
endmodule

// File: rtl/pattern_out_ctrl.sv
module pattern_out_ctrl
  import pat_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BUS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0] port_o,
  output logic [DATA_W-1:0] port_rd_o,
  output logic              trig_o,
  output logic              irq_flag_o,
  output logic              irq_o
);
  localparam int unsigned NGRP   = DATA_W / GRP_W;
  localparam int unsigned NCHAN  = 1 << SEL_W;
  localparam int unsigned TSEL_W = NGRP * SEL_W;

  logic [DATA_W-1:0] next_q, mask_q, dir_q, out_q;
  logic [TSEL_W-1:0] tsel_q;
  logic [CNT_W-1:0]  period_q;
  logic              run_q, irq_en_q, match;
  logic [NCHAN-1:0]  chan_trig;

  pat_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .period_i (period_q),
    .match_o  (match)
  );

  pat_regfile #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .BUS_W  (BUS_W),
    .TSEL_W (TSEL_W)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .match_i   (match),
    .next_o    (next_q),
    .mask_o    (mask_q),
    .dir_o     (dir_q),
    .tsel_o    (tsel_q),
    .period_o  (period_q),
    .run_o     (run_q),
    .irq_en_o  (irq_en_q),
    .flag_o    (irq_flag_o)
  );

  // channel 0 is the local timer; other channels are absent
  assign chan_trig = {{(NCHAN-1){1'b0}}, match};

  pat_out_stage #(
    .DATA_W (DATA_W),
    .GRP_W  (GRP_W),
    .SEL_W  (SEL_W)
  ) i_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chan_trig_i (chan_trig),
    .tsel_i      (tsel_q),
    .next_i      (next_q),
    .mask_i      (mask_q),
    .out_o       (out_q)
  );

  assign port_o    = out_q & dir_q;
  assign port_rd_o = out_q;
  assign trig_o    = match;
  assign irq_o     = irq_flag_o & irq_en_q;

  assert_irq_on_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && irq_en_q && !(wr_en_i && wr_addr_i == REG_CTRL)) |=> irq_o);
  assert_trig_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && period_q != '0) |=> !trig_o);
endmodule

// File: tb/test_pattern_out_ctrl.sv
module test_pattern_out_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  port_o, port_rd_o;
  logic        trig_o, irq_flag_o, irq_o;

  always #5 clk = ~clk;

  pattern_out_ctrl i_pattern_out_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .port_o     (port_o),
    .port_rd_o  (port_rd_o),
    .trig_o     (trig_o),
    .irq_flag_o (irq_flag_o),
    .irq_o      (irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] q_port[$];
  logic [7:0] q_rd[$];
  string      q_tag[$];

  // bench view of the registers (R10 addresses)
  logic [7:0] m_out = 8'h00, m_next = 8'h00, m_mask = 8'h00, m_dir = 8'h00;
  logic [3:0] m_sel = 4'h0;

  localparam logic [7:0] SEQ [12] = '{8'h80, 8'hC0, 8'h40, 8'h60, 8'h20, 8'h30,
                                      8'h10, 8'h18, 8'h08, 8'h88, 8'h80, 8'hC0};

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // call at a negedge: write lands at the next posedge
  task automatic wr_now(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic wait_trig();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!trig_o && n < 200);
  endtask

  // called at the negedge where trig_o is high; queues the expected port
  task automatic push_transfer(string tag);
    logic [7:0] upd;
    upd = 8'h00;
    if (m_sel[1:0] == 2'b00) upd[3:0] = m_mask[3:0];
    if (m_sel[3:2] == 2'b00) upd[7:4] = m_mask[7:4];
    m_out = (m_out & ~upd) | (m_next & upd);
    q_port.push_back(m_out & m_dir);
    q_rd.push_back(m_out);
    q_tag.push_back(tag);
  endtask

  task automatic stop_timer();
    wait_trig();
    @(negedge clk);
    wr_now(3'd5, 16'h0001);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && trig_o) begin
        @(negedge clk);
        if (q_port.size() > 0) begin
          logic [7:0] ep, er;
          string t;
          ep = q_port.pop_front();
          er = q_rd.pop_front();
          t  = q_tag.pop_front();
          check({t, " port"}, {8'h0, port_o}, {8'h0, ep});
          check({t, " readback"}, {8'h0, port_rd_o}, {8'h0, er});
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 port", {8'h0, port_o}, 16'h0);
    check("R1 readback", {8'h0, port_rd_o}, 16'h0);
    check("R1 flag", {15'h0, irq_flag_o}, 16'h0);
    check("R1 irq", {15'h0, irq_o}, 16'h0);

    // R10 configuration through the register map
    wr(3'd2, 16'h00F8); m_dir  = 8'hF8;
    wr(3'd1, 16'h00F8); m_mask = 8'hF8;
    wr(3'd3, 16'h0000); m_sel  = 4'h0;
    wr(3'd4, 16'd4);
    wr(3'd0, 16'h0080); m_next = 8'h80;
    repeat (8) @(negedge clk);
    check("R2 stopped no trigger", {15'h0, trig_o}, 16'h0);
    wr(3'd5, 16'h0003);

    // R9 five-phase sequence
    for (int k = 0; k < 12; k++) begin
      wait_trig();
      push_transfer("R9 sequence");
      @(negedge clk);
      n = $countones(port_o);
      check("R9 one or two phases", {15'h0, (n >= 1 && n <= 2)}, 16'h1);
      if (k == 0) begin
        check("R3 flag set", {15'h0, irq_flag_o}, 16'h1);
        check("R3 irq enabled", {15'h0, irq_o}, 16'h1);
      end
      if (k < 11) begin
        wr_now(3'd0, {8'h0, SEQ[k+1]});
        m_next = SEQ[k+1];
      end
    end

    // R2 trigger spacing and width
    wait_trig();
    @(negedge clk);
    check("R2 pulse width", {15'h0, trig_o}, 16'h0);
    n = 1;
    while (!trig_o && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R2 period+1 spacing", n[15:0], 16'd5);

    // R4 clear, then set-wins
    @(negedge clk);
    wr_now(3'd6, 16'h0001);
    check("R4 write 1 ignored", {15'h0, irq_flag_o}, 16'h1);
    wr_now(3'd6, 16'h0000);
    check("R4 cleared", {15'h0, irq_flag_o}, 16'h0);
    check("R3 irq follows flag", {15'h0, irq_o}, 16'h0);
    wait_trig();
    wr_now(3'd6, 16'h0000);
    check("R4 set wins", {15'h0, irq_flag_o}, 16'h1);

    // R3 enable gating
    wr(3'd6, 16'h0000);
    wr(3'd5, 16'h0002);
    wait_trig();
    @(negedge clk);
    check("R3 flag with irq disabled", {15'h0, irq_flag_o}, 16'h1);
    check("R3 irq masked", {15'h0, irq_o}, 16'h0);

    // R5 partial mask
    stop_timer();
    wr(3'd2, 16'h00FF); m_dir  = 8'hFF;
    wr(3'd1, 16'h003C); m_mask = 8'h3C;
    wr(3'd0, 16'h00A5); m_next = 8'hA5;
    repeat (6) @(negedge clk);
    check("R5 no change without trigger", {8'h0, port_rd_o}, {8'h0, m_out});
    wr(3'd5, 16'h0003);
    wait_trig();
    push_transfer("R5 masked transfer");

    // R8 direction
    stop_timer();
    wr(3'd2, 16'h000F); m_dir = 8'h0F;
    @(negedge clk);
    check("R8 port input bits low", {8'h0, port_o}, {8'h0, m_out & 8'h0F});
    check("R8 readback", {8'h0, port_rd_o}, {8'h0, m_out});

    // R6 group trigger selection
    wr(3'd2, 16'h00FF); m_dir  = 8'hFF;
    wr(3'd1, 16'h00FF); m_mask = 8'hFF;
    wr(3'd3, 16'h0004); m_sel  = 4'h4;
    wr(3'd0, 16'h003C); m_next = 8'h3C;
    wr(3'd5, 16'h0003);
    wait_trig();
    push_transfer("R6 low only");
    stop_timer();
    wr(3'd3, 16'h0003); m_sel  = 4'h3;
    wr(3'd0, 16'h005A); m_next = 8'h5A;
    wr(3'd5, 16'h0003);
    wait_trig();
    push_transfer("R6 high only");
    stop_timer();
    wr(3'd3, 16'h000E); m_sel  = 4'hE;
    wr(3'd0, 16'h0000); m_next = 8'h00;
    wr(3'd5, 16'h0003);
    wait_trig();
    push_transfer("R6 absent channels");

    // R7 write on the trigger cycle
    stop_timer();
    wr(3'd3, 16'h0000); m_sel  = 4'h0;
    wr(3'd0, 16'h0011); m_next = 8'h11;
    wr(3'd5, 16'h0003);
    wait_trig();
    push_transfer("R7 old value");
    wr_now(3'd0, 16'h0099);
    m_next = 8'h99;
    wait_trig();
    push_transfer("R7 new value");
    repeat (3) @(negedge clk);

    check("scoreboard drained", q_port.size()[15:0], 16'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule